// File: doc/BRIEF.md
# Shadow Memory Region Attribute Decoder

This block decides, for one memory address at a time, whether a read and a write to that address are served from internal DRAM or sent out to the external bus. It looks after the upper-memory window from C0000h to FFFFFh. Two configuration bytes set up the window. The region byte and the control byte are each loaded through their own write strobe. A lookup request carries a 20-bit address, and one clock later the block returns a registered pair of attributes together with a valid strobe.

The parameter `LAYOUT` picks one of two window layouts. The uniform layout (0) cuts the window into eight 32 KiB segments. The split layout (1) cuts the lower half of the window into eight 16 KiB segments and the upper half into four 32 KiB segments. In both layouts a single read-select bit and a single write-select bit in the control byte apply to every enabled segment. The block also drives two steady flags that tell whether the system BIOS area is shadowed for reads and for writes.

Top module: `shadow_attr_decoder`

## Requirements
- R1: While reset is asserted and after it is released, both configuration bytes hold 00h. `attrValid`, `rdInternal`, `wrInternal`, `biosShadowRd` and `biosShadowWr` are all 0, so every address goes to the external bus.
- R2: A lookup of any address below C0000h returns `rdInternal`=0 and `wrInternal`=0, whatever the configuration.
- R3: Uniform layout: segment i (i = 0..7) covers C0000h + i×8000h up to 32 KiB further, and region bit i enables it.
- R4: Uniform layout: for an enabled segment, control bit 0 gives `rdInternal` and control bit 1 gives `wrInternal`. All other control bits have no effect on the attributes.
- R5: Uniform layout: `biosShadowRd` = region bit 6 AND control bit 0, and `biosShadowWr` = region bit 6 AND control bit 1.
- R6: Split layout: segment i (i = 0..7) covers C0000h + i×4000h up to 16 KiB further, and region bit i enables it.
- R7: Split layout: segment j (j = 0..3) covers E0000h + j×8000h up to 32 KiB further, and control bit j enables it.
- R8: Split layout: for an enabled segment, control bit 4 gives `rdInternal` and control bit 5 gives `wrInternal`.
- R9: Split layout: `biosShadowRd` equals control bit 4 and `biosShadowWr` equals control bit 5. The region byte does not affect either flag.
- R10: A lookup that falls in a segment that is not enabled returns 0 for both attributes, even when the read-select and write-select bits are set.
- R11: A request sampled at a clock edge drives `attrValid` high, with its attributes, after that same edge and for one cycle only. Without a request `attrValid` is 0, and the attribute outputs keep their last values.
- R12: A configuration byte loaded at an edge becomes visible on the BIOS flags right after that edge and applies to lookups sampled from the next edge on. A lookup sampled at the same edge as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regionWe | input | 1 | Load strobe for the region byte |
| regionData | input | 8 | New region byte |
| controlWe | input | 1 | Load strobe for the control byte |
| controlData | input | 8 | New control byte |
| lookupReq | input | 1 | Address lookup request |
| lookupAddr | input | 20 | Address to classify |
| attrValid | output | 1 | Attributes below belong to the request of the previous edge |
| rdInternal | output | 1 | 1: reads at that address come from internal DRAM |
| wrInternal | output | 1 | 1: writes at that address go to internal DRAM |
| biosShadowRd | output | 1 | System BIOS area is shadowed for reads |
| biosShadowWr | output | 1 | System BIOS area is shadowed for writes |

## Verification
One uniform-layout instance and one split-layout instance receive the same stimulus. This means a single address shows where the two layouts disagree: C8000h and D0000h land in different segments under each layout, and the BIOS flags follow different bits in each. Directed cases test the last byte below the window and both edges of the window and of individual segments, which separates an off-by-one segment index from a correct one. Directed cases also use read-only and write-only control patterns, which catch swapped or wrong select bits, and they issue a configuration write and a lookup at the same edge to confirm that the old value is used. Random configuration bytes then run with addresses that are mostly inside the window. These cover enable and select combinations that the directed cases leave out.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;
  localparam int ADDR_W = 20;
  localparam int CFG_W  = 8;

  // Strobes handed from the control path to the datapath.
  typedef struct packed {
    logic loadRegion;
    logic loadControl;
    logic capture;
  } attrStrobe_t;
endpackage

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
  import shadow_attr_pkg::*;
#(
  parameter int LAYOUT = 0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  regionQ,
  input  logic [CFG_W-1:0]  controlQ,
  output logic              rdHit,
  output logic              wrHit,
  output logic              biosRd,
  output logic              biosWr
);
  // The window is the top quarter of the address space.
  localparam logic [ADDR_W-1:0] WIN_BASE   = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam int                WIN_LOG2   = ADDR_W - 2;
  localparam int                SMALL_LOG2 = WIN_LOG2 - 4;   // 16 KiB
  localparam int                LARGE_LOG2 = SMALL_LOG2 + 1; // 32 KiB
  localparam int                SEG_CNT    = (LAYOUT == 0) ? 8 : 12;
  localparam int                RD_BIT     = (LAYOUT == 0) ? 0 : 4;
  localparam int                WR_BIT     = (LAYOUT == 0) ? 1 : 5;
  localparam int                BIOS_SEG   = 6;

  logic [SEG_CNT-1:0] segHit;

  genvar gi;
  generate
    for (gi = 0; gi < SEG_CNT; gi++) begin : g_seg
      localparam bit IS_SMALL = (LAYOUT != 0) && (gi < 8);
      localparam logic [ADDR_W-1:0] SEG_SIZE =
        IS_SMALL ? ADDR_W'(1 << SMALL_LOG2) : ADDR_W'(1 << LARGE_LOG2);
      localparam logic [ADDR_W-1:0] SEG_BASE =
        (LAYOUT == 0) ? WIN_BASE + ADDR_W'(gi << LARGE_LOG2) :
        IS_SMALL      ? WIN_BASE + ADDR_W'(gi << SMALL_LOG2) :
                        WIN_BASE + ADDR_W'(1 << (WIN_LOG2 - 1))
                                 + ADDR_W'((gi - 8) << LARGE_LOG2);
      logic segEnable;
      if (gi < 8) begin : g_region_en
        assign segEnable = regionQ[gi];
      end else begin : g_control_en
        assign segEnable = controlQ[gi-8];
      end
      logic inRange;
      assign inRange = (addr >= SEG_BASE) &&
                       ({1'b0, addr} < ({1'b0, SEG_BASE} + {1'b0, SEG_SIZE}));
      assign segHit[gi] = inRange && segEnable;
    end

    if (LAYOUT == 0) begin : g_bios_uniform
      assign biosRd = regionQ[BIOS_SEG] & controlQ[RD_BIT];
      assign biosWr = regionQ[BIOS_SEG] & controlQ[WR_BIT];
    end else begin : g_bios_split
      assign biosRd = controlQ[RD_BIT];
      assign biosWr = controlQ[WR_BIT];
    end
  endgenerate

  assign rdHit = (|segHit) & controlQ[RD_BIT];
  assign wrHit = (|segHit) & controlQ[WR_BIT];
endmodule

// File: rtl/shadow_attr_ctrl.sv
module shadow_attr_ctrl
  import shadow_attr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regionWe,
  input  logic        controlWe,
  input  logic        lookupReq,
  output attrStrobe_t strobe,
  output logic        attrValid
);
  always_comb begin
    strobe             = '0;
    strobe.loadRegion  = regionWe;
    strobe.loadControl = controlWe;
    strobe.capture     = lookupReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) attrValid <= 1'b0;
    else       attrValid <= lookupReq;
  end

  // R11: one valid cycle per request, none without
  p_valid_follows_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    lookupReq |=> attrValid);
  p_no_valid_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !lookupReq |=> !attrValid);
endmodule

// File: rtl/shadow_attr_dp.sv
module shadow_attr_dp
  import shadow_attr_pkg::*;
#(
  parameter int LAYOUT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  attrStrobe_t       strobe,
  input  logic [CFG_W-1:0]  regionData,
  input  logic [CFG_W-1:0]  controlData,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              rdInternal,
  output logic              wrInternal,
  output logic              biosShadowRd,
  output logic              biosShadowWr
);
  localparam logic [ADDR_W-1:0] WIN_BASE = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam int                RD_BIT   = (LAYOUT == 0) ? 0 : 4;
  localparam int                WR_BIT   = (LAYOUT == 0) ? 1 : 5;

  logic [CFG_W-1:0] regionQ;
  logic [CFG_W-1:0] controlQ;
  logic             rdHit;
  logic             wrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regionQ  <= '0;
      controlQ <= '0;
    end else begin
      if (strobe.loadRegion)  regionQ  <= regionData;
      if (strobe.loadControl) controlQ <= controlData;
    end
  end

  shadow_seg_decode #(.LAYOUT(LAYOUT)) i_seg_decode (
    .addr     (lookupAddr),
    .regionQ  (regionQ),
    .controlQ (controlQ),
    .rdHit    (rdHit),
    .wrHit    (wrHit),
    .biosRd   (biosShadowRd),
    .biosWr   (biosShadowWr)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdInternal <= 1'b0;
      wrInternal <= 1'b0;
    end else if (strobe.capture) begin
      rdInternal <= rdHit;
      wrInternal <= wrHit;
    end
  end

  // R1: reset leaves configuration and attributes cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (regionQ == '0) && (controlQ == '0) && !rdInternal && !wrInternal);

  // R2: below the window nothing is internal
  p_low_external_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && (lookupAddr < WIN_BASE) |=> !rdInternal && !wrInternal);

  // R4 / R8: an internal attribute needs its select bit
  p_rd_needs_select_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && !controlQ[RD_BIT] |=> !rdInternal);
  p_wr_needs_select_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && !controlQ[WR_BIT] |=> !wrInternal);

  // R10: with no segment enabled every lookup is external
  generate
    if (LAYOUT == 0) begin : g_chk_uniform
      p_no_enable_external_r10: assert property (@(posedge clk) disable iff (!rstN)
        strobe.capture && (regionQ == '0) |=> !rdInternal && !wrInternal);
    end else begin : g_chk_split
      p_no_enable_external_r10: assert property (@(posedge clk) disable iff (!rstN)
        strobe.capture && (regionQ == '0) && (controlQ[3:0] == 4'h0)
        |=> !rdInternal && !wrInternal);
    end
  endgenerate
endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
  import shadow_attr_pkg::*;
#(
  parameter int LAYOUT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regionWe,
  input  logic [CFG_W-1:0]  regionData,
  input  logic              controlWe,
  input  logic [CFG_W-1:0]  controlData,
  input  logic              lookupReq,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              attrValid,
  output logic              rdInternal,
  output logic              wrInternal,
  output logic              biosShadowRd,
  output logic              biosShadowWr
);
  attrStrobe_t strobe;

  shadow_attr_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regionWe  (regionWe),
    .controlWe (controlWe),
    .lookupReq (lookupReq),
    .strobe    (strobe),
    .attrValid (attrValid)
  );

  shadow_attr_dp #(.LAYOUT(LAYOUT)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .regionData   (regionData),
    .controlData  (controlData),
    .lookupAddr   (lookupAddr),
    .rdInternal   (rdInternal),
    .wrInternal   (wrInternal),
    .biosShadowRd (biosShadowRd),
    .biosShadowWr (biosShadowWr)
  );
endmodule

// File: tb/test_shadow_attr_decoder.sv
`timescale 1ns/1ps
module test_shadow_attr_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regionWe = 1'b0;
  logic [7:0]  regionData = '0;
  logic        controlWe = 1'b0;
  logic [7:0]  controlData = '0;
  logic        lookupReq = 1'b0;
  logic [19:0] lookupAddr = '0;
  logic        validA, rdA, wrA, biosRdA, biosWrA;
  logic        validB, rdB, wrB, biosRdB, biosWrB;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] regM = '0;
  logic [7:0] ctlM = '0;

  always #4 clk = ~clk;  // 125 MHz

  shadow_attr_decoder #(.LAYOUT(0)) i_shadow_attr_decoder (
    .clk(clk), .rstN(rstN), .regionWe(regionWe), .regionData(regionData),
    .controlWe(controlWe), .controlData(controlData), .lookupReq(lookupReq),
    .lookupAddr(lookupAddr), .attrValid(validA), .rdInternal(rdA),
    .wrInternal(wrA), .biosShadowRd(biosRdA), .biosShadowWr(biosWrA));

  shadow_attr_decoder #(.LAYOUT(1)) i_shadow_attr_decoder_split (
    .clk(clk), .rstN(rstN), .regionWe(regionWe), .regionData(regionData),
    .controlWe(controlWe), .controlData(controlData), .lookupReq(lookupReq),
    .lookupAddr(lookupAddr), .attrValid(validB), .rdInternal(rdB),
    .wrInternal(wrB), .biosShadowRd(biosRdB), .biosShadowWr(biosWrB));

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected {rd, wr} for one layout
  function automatic logic [1:0] expAttr(input bit split, input logic [7:0] r,
                                         input logic [7:0] c, input logic [19:0] a);
    logic en = 1'b0;
    int   idx;
    if (a >= 20'hC0000) begin
      if (!split) begin
        idx = int'(a - 20'hC0000) / 32768;
        en  = r[idx];
      end else if (a < 20'hE0000) begin
        idx = int'(a - 20'hC0000) / 16384;
        en  = r[idx];
      end else begin
        idx = int'(a - 20'hE0000) / 32768;
        en  = c[idx];
      end
    end
    if (!split) return {en & c[0], en & c[1]};
    return {en & c[4], en & c[5]};
  endfunction

  function automatic logic [1:0] expBios(input bit split, input logic [7:0] r,
                                         input logic [7:0] c);
    if (!split) return {r[6] & c[0], r[6] & c[1]};
    return {c[4], c[5]};
  endfunction

  task automatic checkBios(input string req);
    logic [1:0] ea = expBios(1'b0, regM, ctlM);
    logic [1:0] eb = expBios(1'b1, regM, ctlM);
    chk(req, "uniform biosRd", int'(biosRdA), int'(ea[1]));
    chk(req, "uniform biosWr", int'(biosWrA), int'(ea[0]));
    chk(req, "split biosRd",   int'(biosRdB), int'(eb[1]));
    chk(req, "split biosWr",   int'(biosWrB), int'(eb[0]));
  endtask

  task automatic writeCfg(input logic [7:0] r, input logic [7:0] c, input string req);
    @(negedge clk);
    regionWe = 1'b1; regionData = r; controlWe = 1'b1; controlData = c;
    @(posedge clk);
    regM = r; ctlM = c;
    @(negedge clk);
    regionWe = 1'b0; controlWe = 1'b0;
    checkBios(req);
  endtask

  task automatic checkAttr(input string req, input logic [19:0] a,
                           input logic [7:0] r, input logic [7:0] c);
    logic [1:0] ea = expAttr(1'b0, r, c, a);
    logic [1:0] eb = expAttr(1'b1, r, c, a);
    chk(req, $sformatf("uniform valid @%05h", a), int'(validA), 1);
    chk(req, $sformatf("uniform rd @%05h", a), int'(rdA), int'(ea[1]));
    chk(req, $sformatf("uniform wr @%05h", a), int'(wrA), int'(ea[0]));
    chk(req, $sformatf("split valid @%05h", a), int'(validB), 1);
    chk(req, $sformatf("split rd @%05h", a), int'(rdB), int'(eb[1]));
    chk(req, $sformatf("split wr @%05h", a), int'(wrB), int'(eb[0]));
  endtask

  task automatic lookup(input logic [19:0] a, input string req);
    @(negedge clk);
    lookupReq = 1'b1; lookupAddr = a;
    @(negedge clk);
    lookupReq = 1'b0;
    checkAttr(req, a, regM, ctlM);
  endtask

  initial begin : main
    logic [19:0] a;
    logic [7:0]  oldR;
    logic [7:0]  oldC;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "uniform valid", int'(validA), 0);
    chk("R1", "split valid", int'(validB), 0);
    chk("R1", "uniform rd", int'(rdA), 0);
    chk("R1", "split wr", int'(wrB), 0);
    checkBios("R1");
    rstN = 1'b1;
    lookup(20'hF0000, "R1");
    lookup(20'hC0000, "R1");

    // R2: below the window with everything enabled
    writeCfg(8'hFF, 8'hFF, "R9");
    lookup(20'hBFFFF, "R2");
    lookup(20'h00000, "R2");
    lookup(20'hC0000, "R3");
    lookup(20'hFFFFF, "R7");

    // R3 / R6: single region bit, layouts disagree
    writeCfg(8'h04, 8'h33, "R5");
    lookup(20'hD0000, "R3");
    lookup(20'hCFFFF, "R3");
    lookup(20'hC8000, "R6");
    lookup(20'hCC000, "R6");
    lookup(20'hC7FFF, "R6");

    // R7: upper segments from control bits
    writeCfg(8'h00, 8'h3A, "R9");
    lookup(20'hE8000, "R7");
    lookup(20'hE7FFF, "R7");
    lookup(20'hF8000, "R7");
    lookup(20'hF7FFF, "R7");
    lookup(20'hE0000, "R7");

    // R10: selects set but nothing enabled
    writeCfg(8'h00, 8'h33, "R10");
    lookup(20'hC0000, "R10");
    lookup(20'hF0000, "R10");
    lookup(20'hDC000, "R10");

    // R4 / R8: read-only and write-only patterns; R5 BIOS flags
    writeCfg(8'hFF, 8'h01, "R5");
    lookup(20'hF0000, "R4");
    writeCfg(8'hFF, 8'h02, "R5");
    lookup(20'hD4000, "R4");
    writeCfg(8'hBF, 8'h1F, "R9");
    lookup(20'hF4000, "R8");
    writeCfg(8'hFF, 8'h2F, "R8");
    lookup(20'hE4000, "R8");
    writeCfg(8'h40, 8'hFC, "R4");
    lookup(20'hF0000, "R4");

    // R12: write and lookup at the same edge use the old configuration
    writeCfg(8'h00, 8'h00, "R12");
    @(negedge clk);
    oldR = regM; oldC = ctlM;
    regionWe = 1'b1; regionData = 8'hFF; controlWe = 1'b1; controlData = 8'h3F;
    lookupReq = 1'b1; lookupAddr = 20'hC4000;
    @(posedge clk);
    regM = 8'hFF; ctlM = 8'h3F;
    @(negedge clk);
    regionWe = 1'b0; controlWe = 1'b0; lookupReq = 1'b0;
    checkAttr("R12", 20'hC4000, oldR, oldC);
    checkBios("R12");
    lookup(20'hC4000, "R12");

    // R11: valid drops after one cycle, attributes hold
    @(negedge clk);
    chk("R11", "uniform valid idle", int'(validA), 0);
    chk("R11", "split valid idle", int'(validB), 0);
    chk("R11", "uniform rd held", int'(rdA), 1);
    chk("R11", "split wr held", int'(wrB), 1);

    // Random configurations and addresses
    for (int it = 0; it < 300; it++) begin
      writeCfg(8'($urandom), 8'($urandom), "R9");
      for (int k = 0; k < 4; k++) begin
        if ($urandom_range(3) == 0) a = 20'($urandom);
        else a = 20'hC0000 | 20'($urandom_range(20'h3FFFF));
        lookup(a, (a < 20'hC0000) ? "R2" : "R10");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule